// File: doc/BRIEF.md
# Coefficient Store with Default Preload

This block keeps the coefficient table that a digital servo's filters read. The table has 128 entries of 8 bits. When reset is released the block fills every entry from a built-in table of defaults, one entry per clock, and then keeps a busy flag high until a fixed boot interval has passed. Once the block is idle, a host can change single entries with 24-bit rewrite commands.

A rewrite command carries an 8-bit code, a reserved bit that must be zero, a 7-bit entry index and an 8-bit value. An accepted command starts a fixed busy window. The new value is written into the table at the end of that window. A command that arrives while the block is busy is dropped, and a sticky error flag records it. A malformed command that arrives while the block is idle is ignored without a trace. A combinational read port gives the filter datapath any entry.

Top module: `coef_ram`

## Requirements
- R1: After reset is released, `busy` stays high for exactly BOOT_CYCLES (226) clock cycles, counted from the release cycle, and then falls.
- R2: After the boot interval, entry a holds its default value (37*a + 5) mod 256, for every a from 0 to 127.
- R3: `rd_data` shows the stored value of entry `rd_addr` in the same cycle that `rd_addr` is applied, with no clock edge in between.
- R4: A command is accepted when `cmd_valid` is high for one cycle while `busy` is low, bits 23:16 equal 0x34 and bit 15 is 0. Bits 14:8 select the entry and bits 7:0 give the value. `busy` rises at the next clock edge.
- R5: After an accepted command, `busy` stays high for exactly WRITE_CYCLES (64) cycles. `rd_data` keeps showing the old value of the entry for that whole window, and shows the new value from the cycle in which `busy` falls.
- R6: A command presented while idle with a code other than 0x34, or with bit 15 set, is ignored: `busy` stays low, `err` stays low and no entry changes.
- R7: A command presented while `busy` is high, during the boot interval or during a rewrite window, is dropped without changing any entry, and `err` is high from the next clock edge.
- R8: `err` stays high until `err_clr` is pulsed. When `err_clr` and a new error condition occur in the same cycle, the new error wins and `err` stays high.
- R9: While `rst_n` is low, `busy` is 1 and `err` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Rewrite command strobe, one cycle |
| cmd_word | input | 24 | Command: code [23:16], reserved [15], index [14:8], value [7:0] |
| err_clr | input | 1 | Clears the sticky error flag |
| rd_addr | input | 7 | Read index from the filter datapath |
| rd_data | output | 8 | Coefficient at `rd_addr` |
| busy | output | 1 | High during the boot copy and during each rewrite window |
| err | output | 1 | Sticky flag set by a command that arrived while busy |

## Verification
Assertions check on every cycle that:
- a command arriving while busy raises the error flag,
- the error flag holds until it is cleared,
- an accepted command raises busy,
- every table write lands at its index,
- the read output is stable when nothing is written and the read index does not change.

Only the bench scenarios can show the behaviour that depends on exact counts and contents:
- the exact lengths of the boot interval and the rewrite window,
- the full table of defaults after boot,
- that a new value stays hidden until the window closes,
- that malformed or dropped commands leave the table unchanged.

// File: rtl/coef_pkg.sv
package coef_pkg;
    typedef enum logic [1:0] {
        ST_BOOT  = 2'd0,
        ST_IDLE  = 2'd1,
        ST_WRITE = 2'd2
    } ctrl_state_e;
endpackage

// File: rtl/coef_rom.sv
module coef_rom #(
    parameter int AW      = 7,
    parameter int DW      = 8,
    parameter int ROM_MUL = 37,
    parameter int ROM_ADD = 5
) (
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] data
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] tbl [DEPTH];

    // The default table is computed per entry, so no list is written out.
    for (genvar i = 0; i < DEPTH; i++) begin : g_tbl
        assign tbl[i] = DW'(i * ROM_MUL + ROM_ADD);
    end

    assign data = tbl[addr];
endmodule

// File: rtl/coef_cmd_decode.sv
module coef_cmd_decode #(
    parameter int AW     = 7,
    parameter int DW     = 8,
    parameter int CODE_W = 8,
    parameter logic [CODE_W-1:0] CODE = 8'h34,
    localparam int CMD_W = CODE_W + 1 + AW + DW
) (
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    output logic             cmd_legal,
    output logic [AW-1:0]    cmd_addr,
    output logic [DW-1:0]    cmd_data
);
    localparam int RSV_BIT = DW + AW;

    logic code_ok;
    logic rsv_ok;

    always_comb begin
        code_ok   = (cmd_word[CMD_W-1 -: CODE_W] == CODE);
        rsv_ok    = !cmd_word[RSV_BIT];
        cmd_legal = cmd_valid && code_ok && rsv_ok;
        cmd_addr  = cmd_word[DW +: AW];
        cmd_data  = cmd_word[DW-1:0];
    end
endmodule

// File: rtl/coef_store.sv
module coef_store #(
    parameter int AW = 7,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] wa,
    input  logic [DW-1:0] wd,
    input  logic [AW-1:0] ra,
    output logic [DW-1:0] rd
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];
    logic [DW-1:0] mem_d [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) begin
            mem_d[wa] = wd;
        end
    end

    always_ff @(posedge clk) begin
        mem_q <= mem_d;
    end

    assign rd = mem_q[ra];

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
        we |=> (mem_q[$past(wa)] == $past(wd))); // R5

    AST_RD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!we && $stable(ra)) |-> ##1 (!$stable(ra) || $stable(rd) || $past(!rst_n))); // R6
endmodule

// File: rtl/coef_ctrl.sv
module coef_ctrl
    import coef_pkg::*;
#(
    parameter int AW           = 7,
    parameter int DW           = 8,
    parameter int BOOT_CYCLES  = 226,
    parameter int WRITE_CYCLES = 64
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cmd_valid,
    input  logic          cmd_legal,
    input  logic [AW-1:0] cmd_addr,
    input  logic [DW-1:0] cmd_data,
    input  logic          err_clr,
    output logic [AW-1:0] rom_addr,
    input  logic [DW-1:0] rom_data,
    output logic          we,
    output logic [AW-1:0] wa,
    output logic [DW-1:0] wd,
    output logic          busy,
    output logic          err
);
    localparam int DEPTH = 1 << AW;
    localparam int MAXA  = (BOOT_CYCLES > WRITE_CYCLES) ? BOOT_CYCLES : WRITE_CYCLES;
    localparam int MAXC  = (MAXA > DEPTH) ? MAXA : DEPTH;
    localparam int CNT_W = $clog2(MAXC + 1);

    localparam logic [CNT_W-1:0] BOOT_LAST  = CNT_W'(BOOT_CYCLES - 1);
    localparam logic [CNT_W-1:0] WRITE_LAST = CNT_W'(WRITE_CYCLES - 1);
    localparam logic [CNT_W-1:0] DEPTH_C    = CNT_W'(DEPTH);

    typedef struct packed {
        ctrl_state_e      state;
        logic [CNT_W-1:0] cnt;
        logic [AW-1:0]    addr;
        logic [DW-1:0]    data;
        logic             err;
    } ctrl_t;

    ctrl_t cur_q, nxt_d;
    logic  accept;

    always_comb begin
        nxt_d    = cur_q;
        we       = 1'b0;
        wa       = cur_q.cnt[AW-1:0];
        wd       = rom_data;
        rom_addr = cur_q.cnt[AW-1:0];
        busy     = (cur_q.state != ST_IDLE);
        accept   = 1'b0;

        case (cur_q.state)
            ST_BOOT: begin
                if (cur_q.cnt < DEPTH_C) begin
                    we = 1'b1;
                end
                if (cur_q.cnt == BOOT_LAST) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            ST_IDLE: begin
                if (cmd_legal) begin
                    accept      = 1'b1;
                    nxt_d.state = ST_WRITE;
                    nxt_d.cnt   = '0;
                    nxt_d.addr  = cmd_addr;
                    nxt_d.data  = cmd_data;
                end
            end
            ST_WRITE: begin
                if (cur_q.cnt == WRITE_LAST) begin
                    we          = 1'b1;
                    wa          = cur_q.addr;
                    wd          = cur_q.data;
                    nxt_d.state = ST_IDLE;
                    nxt_d.cnt   = '0;
                end else begin
                    nxt_d.cnt = cur_q.cnt + 1'b1;
                end
            end
            default: begin
                nxt_d.state = ST_IDLE;
                nxt_d.cnt   = '0;
            end
        endcase

        if (cmd_valid && busy) begin
            nxt_d.err = 1'b1;
        end else if (err_clr) begin
            nxt_d.err = 1'b0;
        end

        err = cur_q.err;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '{state: ST_BOOT, cnt: '0, addr: '0, data: '0, err: 1'b0};
        end else begin
            cur_q <= nxt_d;
        end
    end

    AST_BUSY_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && busy) |=> err); // R7

    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (err && !err_clr) |=> err); // R8

    AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> busy); // R4

    AST_RESET_VALUES: assert property (@(posedge clk)
        !rst_n |-> (busy && !err)); // R9
endmodule

// File: rtl/coef_ram.sv
module coef_ram #(
    parameter int AW           = 7,
    parameter int DW           = 8,
    parameter int CODE_W       = 8,
    parameter logic [CODE_W-1:0] CODE = 8'h34,
    parameter int BOOT_CYCLES  = 226,
    parameter int WRITE_CYCLES = 64,
    parameter int ROM_MUL      = 37,
    parameter int ROM_ADD      = 5,
    localparam int CMD_W       = CODE_W + 1 + AW + DW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmd_valid,
    input  logic [CMD_W-1:0] cmd_word,
    input  logic             err_clr,
    input  logic [AW-1:0]    rd_addr,
    output logic [DW-1:0]    rd_data,
    output logic             busy,
    output logic             err
);
    logic          cmd_legal;
    logic [AW-1:0] cmd_addr;
    logic [DW-1:0] cmd_data;
    logic [AW-1:0] rom_addr;
    logic [DW-1:0] rom_data;
    logic          we;
    logic [AW-1:0] wa;
    logic [DW-1:0] wd;

    coef_cmd_decode #(
        .AW(AW), .DW(DW), .CODE_W(CODE_W), .CODE(CODE)
    ) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .cmd_legal (cmd_legal),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data)
    );

    coef_rom #(
        .AW(AW), .DW(DW), .ROM_MUL(ROM_MUL), .ROM_ADD(ROM_ADD)
    ) u_rom (
        .addr (rom_addr),
        .data (rom_data)
    );

    coef_ctrl #(
        .AW(AW), .DW(DW), .BOOT_CYCLES(BOOT_CYCLES), .WRITE_CYCLES(WRITE_CYCLES)
    ) u_ctrl (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_legal (cmd_legal),
        .cmd_addr  (cmd_addr),
        .cmd_data  (cmd_data),
        .err_clr   (err_clr),
        .rom_addr  (rom_addr),
        .rom_data  (rom_data),
        .we        (we),
        .wa        (wa),
        .wd        (wd),
        .busy      (busy),
        .err       (err)
    );

    coef_store #(
        .AW(AW), .DW(DW)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (we),
        .wa    (wa),
        .wd    (wd),
        .ra    (rd_addr),
        .rd    (rd_data)
    );
endmodule

// File: tb/coef_ram_tb.sv
module coef_ram_tb;
    localparam int BOOT_N  = 226;
    localparam int WRITE_N = 64;
    localparam int NVEC    = 8;

    // {command word, 1 = accepted}
    localparam logic [24:0] VEC [NVEC] = '{
        {24'h34_05_A5, 1'b1},
        {24'h34_7F_11, 1'b1},
        {24'h34_00_FE, 1'b1},
        {24'h35_10_22, 1'b0},
        {24'h34_90_33, 1'b0},
        {24'h00_20_44, 1'b0},
        {24'h34_20_44, 1'b1},
        {24'hB4_30_55, 1'b0}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [23:0] cmd_word = '0;
    logic        err_clr = 1'b0;
    logic [6:0]  rd_addr = '0;
    logic [7:0]  rd_data;
    logic        busy;
    logic        err;

    int checks = 0;
    int fails  = 0;
    logic [7:0] model [128];

    always #10 clk = ~clk;

    coef_ram u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .err_clr(err_clr), .rd_addr(rd_addr), .rd_data(rd_data),
        .busy(busy), .err(err)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic model_init();
        for (int a = 0; a < 128; a++) model[a] = 8'((37 * a + 5) % 256);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        #1;
        chk("R9 busy", int'(busy), 1);
        chk("R9 err", int'(err), 0);
        @(negedge clk);
        rst_n = 1'b1;
        model_init();
    endtask

    task automatic send(input logic [23:0] w);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = w;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    initial begin
        #(20 * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        int n;
        do_reset();
        // R1: boot length
        n = 0;
        while (busy === 1'b1 && n < 1000) begin
            n++;
            @(negedge clk);
        end
        chk("R1 boot cycles", n, BOOT_N);
        // R2 and R3: every default, read combinationally
        for (int a = 0; a < 128; a++) begin
            rd_addr = 7'(a);
            #1;
            chk("R2 R3 default", int'(rd_data), int'(model[a]));
        end
        @(negedge clk);

        // table walk: R4, R5, R6
        for (int v = 0; v < NVEC; v++) begin
            logic [23:0] w;
            logic [6:0]  ad;
            w  = VEC[v][24:1];
            ad = w[14:8];
            rd_addr = ad;
            send(w);
            #1;
            if (VEC[v][0]) begin
                chk("R4 busy rises", int'(busy), 1);
                n = 0;
                while (busy === 1'b1 && n < 1000) begin
                    n++;
                    chk("R5 old value held", int'(rd_data), int'(model[ad]));
                    @(negedge clk);
                    #1;
                end
                chk("R5 window", n, WRITE_N);
                model[ad] = w[7:0];
                chk("R5 new value", int'(rd_data), int'(model[ad]));
            end else begin
                chk("R6 no busy", int'(busy), 0);
                chk("R6 no err", int'(err), 0);
                chk("R6 unchanged", int'(rd_data), int'(model[ad]));
            end
        end

        // R7 during boot, R8 sticky and clear
        do_reset();
        repeat (5) @(negedge clk);
        send(24'h34_03_00);
        #1;
        chk("R7 err during boot", int'(err), 1);
        while (busy === 1'b1) @(negedge clk);
        rd_addr = 7'd3;
        #1;
        chk("R7 boot entry kept", int'(rd_data), int'(model[3]));
        repeat (3) @(negedge clk);
        chk("R8 sticky", int'(err), 1);
        @(negedge clk);
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
        chk("R8 cleared", int'(err), 0);

        // R7 during write window, R8 set beats clear
        rd_addr = 7'd10;
        send(24'h34_0A_5A);
        @(negedge clk);
        cmd_valid = 1'b1;
        cmd_word  = 24'h34_0A_FF;
        err_clr   = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        err_clr   = 1'b0;
        chk("R8 set wins", int'(err), 1);
        while (busy === 1'b1) @(negedge clk);
        #1;
        chk("R7 dropped cmd", int'(rd_data), 8'h5A);
        repeat (3) @(negedge clk);
        chk("R7 no late write", int'(rd_data), 8'h5A);

        $display("  test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end
endmodule